// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a segment value and an effective offset into a linear address. It has two paths. In real mode the 16-bit segment value names a paragraph: it is shifted left by four bits and added to the low 16 bits of the offset, which gives a 20-bit address. In protected mode the segment value is a selector. The selector picks a descriptor from a small on-block cache, which has one bank for the global table and one for the local table. The descriptor base is added to the offset. The offset, widened by the access size, is then checked against the effective segment limit. The limit is scaled up to 4 KB units when the descriptor's granularity bit is set.

The block accepts one request per cycle and answers each request one cycle later. A granted access raises `lin_valid` together with the linear address and the operand-size flag. A limit violation raises `lin_fault` and holds `lin_valid` low. The descriptor cache stands in for the in-memory tables and is filled through a write port.

The result is held by a four-state machine that records what the previous cycle produced:

- `ST_IDLE`: no request.
- `ST_REAL_DONE`: a real-mode translation.
- `ST_PROT_DONE`: a protected-mode translation that passed the limit check.
- `ST_LIMIT_FAULT`: a protected-mode access that violated its limit.

Transitions on every clock:

- Any state goes to `ST_IDLE` when `req_valid` is low.
- Any state goes to `ST_REAL_DONE` on a request with `req_prot` low.
- Any state goes to `ST_PROT_DONE` on a protected request inside its limit.
- Any state goes to `ST_LIMIT_FAULT` on a protected request beyond its limit.
- Reset enters `ST_IDLE`.

Top module: `seg_xlat_unit`

## Requirements
- R1: While and right after reset, `lin_valid`, `lin_fault`, `lin_opsize32` are 0 and `lin_addr` is 0.
- R2: A request sampled on a rising edge produces its result right after that edge, for one cycle. A cycle without a request shows `lin_valid` and `lin_fault` low on the next cycle. Back-to-back requests each get their own result cycle.
- R3: In real mode (`req_prot`=0), `lin_addr` = ({`req_seg`, 4'h0} + `req_offset`[15:0]) modulo 2^20. Bits 31:20 are zero, and `req_offset`[31:16] has no effect.
- R4: A real-mode request never faults. It raises `lin_valid` and drives `lin_opsize32` low.
- R5: In protected mode, a granted access gives `lin_addr` = (descriptor base + `req_offset`) modulo 2^32.
- R6: With granularity 0, the effective limit is the 20-bit limit in bytes. The access faults when `req_offset` + size − 1 > limit.
- R7: With granularity 1, the effective limit is {limit, 12'hFFF}.
- R8: `req_size` encodes the access width: 0 = 1 byte, 1 = 2 bytes, 2 and 3 = 4 bytes.
- R9: On a fault, `lin_fault`=1, `lin_valid`=0, `lin_addr`=0 and `lin_opsize32`=0.
- R10: On a granted protected access, `lin_opsize32` equals the descriptor's operand-size bit (1 = 32-bit segment).
- R11: Selector bit 2 picks the bank (0 global, 1 local), and selector bits 4:3 pick the entry (default depth 4). Selector bits 15:5 and 1:0 have no effect.
- R12: A cache write (`cw_en`=1) stores the descriptor at (`cw_local`, `cw_idx`). A request in the same cycle still sees the old entry, and later requests see the new one. Reset clears every entry to base 0, limit 0, granularity 0, size bit 0.
- R13: The limit check uses the full sum of offset and size − 1, without wrap-around. An access whose last byte passes 2^32 − 1 faults even with the largest effective limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cw_en | input | 1 | Descriptor cache write strobe |
| cw_local | input | 1 | Bank written: 0 global, 1 local |
| cw_idx | input | 2 | Entry written within the bank |
| cw_base | input | 32 | Descriptor base address |
| cw_limit | input | 20 | Descriptor limit |
| cw_gran | input | 1 | Descriptor granularity (1 = 4 KB units) |
| cw_big | input | 1 | Descriptor operand-size bit |
| req_valid | input | 1 | Translation request strobe |
| req_prot | input | 1 | 0 real mode, 1 protected mode |
| req_seg | input | 16 | Segment value or selector |
| req_offset | input | 32 | Effective offset |
| req_size | input | 2 | Access width code |
| lin_valid | output | 1 | Granted translation result |
| lin_fault | output | 1 | Limit violation result |
| lin_addr | output | 32 | Linear address |
| lin_opsize32 | output | 1 | Operand size of the segment used |

## Verification
The assertions assume that `req_valid` and `req_prot` are known on every sampled edge after reset. They also assume that `req_valid` is low while reset is applied. Their past-cycle checks therefore never see an undefined request. The stimulus drives all inputs on falling edges and holds each request for exactly one cycle. It keeps `req_valid` low during reset and during cache loads, so the relation between a request and its result stays unambiguous. Corner offsets are chosen so that the last byte of an access lands exactly on, or one past, the effective limit, and once past 2^32.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    parameter int unsigned SX_ADDR_W  = 32;
    parameter int unsigned SX_SEL_W   = 16;
    parameter int unsigned SX_LIM_W   = 20;
    parameter int unsigned SX_PAGE_SH = 12;
    parameter int unsigned SX_PARA_SH = 4;
    parameter int unsigned SX_REAL_W  = SX_SEL_W + SX_PARA_SH;
    parameter int unsigned SX_OFF16_W = 16;
    parameter int unsigned SX_TBL_BIT = 2;
    parameter int unsigned SX_IDX_LSB = 3;

    typedef struct packed {
        logic [SX_ADDR_W-1:0] base;
        logic [SX_LIM_W-1:0]  limit;
        logic                 gran;
        logic                 big;
    } seg_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_REAL_DONE   = 2'd1,
        ST_PROT_DONE   = 2'd2,
        ST_LIMIT_FAULT = 2'd3
    } xlat_state_t;

    function automatic logic [SX_ADDR_W-1:0] span_minus_one(input logic [1:0] code);
        logic [SX_ADDR_W-1:0] r;
        unique case (code)
            2'd0:    r = SX_ADDR_W'(0);
            2'd1:    r = SX_ADDR_W'(1);
            default: r = SX_ADDR_W'(3);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
    import seg_xlat_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned SLOTS = 2 * DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_local,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_desc_t        wr_desc,
    input  logic             rd_local,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_desc_t        rd_desc
);

    seg_desc_t slot_view [SLOTS];

    generate
        for (genvar t = 0; t < 2; t++) begin : g_bank
            for (genvar e = 0; e < DEPTH; e++) begin : g_entry
                seg_desc_t ent_q;
                logic      hit;

                assign hit = wr_en && (wr_local == 1'(t)) && (wr_idx == IDX_W'(e));

                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        ent_q <= '0;
                    end else if (hit) begin
                        ent_q <= wr_desc;
                    end
                end

                assign slot_view[t*DEPTH + e] = ent_q;
            end
        end
    endgenerate

    assign rd_desc = slot_view[{rd_local, rd_idx}];

endmodule

// File: rtl/seg_real_path.sv
module seg_real_path
    import seg_xlat_pkg::*;
(
    input  logic [SX_SEL_W-1:0]   seg,
    input  logic [SX_OFF16_W-1:0] off,
    output logic [SX_ADDR_W-1:0]  addr
);

    logic [SX_REAL_W-1:0] para;
    logic [SX_REAL_W-1:0] sum;

    assign para = {seg, {SX_PARA_SH{1'b0}}};
    assign sum  = para + {{(SX_REAL_W-SX_OFF16_W){1'b0}}, off};
    assign addr = {{(SX_ADDR_W-SX_REAL_W){1'b0}}, sum};

endmodule

// File: rtl/seg_prot_path.sv
module seg_prot_path
    import seg_xlat_pkg::*;
(
    input  logic [SX_ADDR_W-1:0] base,
    input  logic [SX_LIM_W-1:0]  limit,
    input  logic                 gran,
    input  logic [SX_ADDR_W-1:0] off,
    input  logic [1:0]           size,
    output logic [SX_ADDR_W-1:0] addr,
    output logic                 viol
);

    localparam int unsigned EXT_W = SX_ADDR_W + 1;

    logic [SX_ADDR_W-1:0] eff_lim;
    logic [EXT_W-1:0]     last_byte;

    always_comb begin
        if (gran) begin
            eff_lim = {limit, {SX_PAGE_SH{1'b1}}};
        end else begin
            eff_lim = {{(SX_ADDR_W-SX_LIM_W){1'b0}}, limit};
        end
    end

    assign last_byte = {1'b0, off} + {1'b0, span_minus_one(size)};
    assign viol      = last_byte > {1'b0, eff_lim};
    assign addr      = base + off;

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
#(
    parameter int unsigned CACHE_DEPTH = 4,
    localparam int unsigned CIDX_W = $clog2(CACHE_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cw_en,
    input  logic                 cw_local,
    input  logic [CIDX_W-1:0]    cw_idx,
    input  logic [SX_ADDR_W-1:0] cw_base,
    input  logic [SX_LIM_W-1:0]  cw_limit,
    input  logic                 cw_gran,
    input  logic                 cw_big,
    input  logic                 req_valid,
    input  logic                 req_prot,
    input  logic [SX_SEL_W-1:0]  req_seg,
    input  logic [SX_ADDR_W-1:0] req_offset,
    input  logic [1:0]           req_size,
    output logic                 lin_valid,
    output logic                 lin_fault,
    output logic [SX_ADDR_W-1:0] lin_addr,
    output logic                 lin_opsize32
);

    xlat_state_t          state_q, state_d;
    seg_desc_t            wr_desc, rd_desc;
    logic [SX_ADDR_W-1:0] real_addr, prot_addr, addr_q;
    logic                 prot_viol, big_q;

    assign wr_desc = '{base: cw_base, limit: cw_limit, gran: cw_gran, big: cw_big};

    seg_desc_cache #(.DEPTH(CACHE_DEPTH)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cw_en),
        .wr_local (cw_local),
        .wr_idx   (cw_idx),
        .wr_desc  (wr_desc),
        .rd_local (req_seg[SX_TBL_BIT]),
        .rd_idx   (req_seg[SX_IDX_LSB +: CIDX_W]),
        .rd_desc  (rd_desc)
    );

    seg_real_path u_real (
        .seg  (req_seg),
        .off  (req_offset[SX_OFF16_W-1:0]),
        .addr (real_addr)
    );

    seg_prot_path u_prot (
        .base  (rd_desc.base),
        .limit (rd_desc.limit),
        .gran  (rd_desc.gran),
        .off   (req_offset),
        .size  (req_size),
        .addr  (prot_addr),
        .viol  (prot_viol)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (!req_prot) begin
                state_d = ST_REAL_DONE;
            end else if (prot_viol) begin
                state_d = ST_LIMIT_FAULT;
            end else begin
                state_d = ST_PROT_DONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            big_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                addr_q <= req_prot ? prot_addr : real_addr;
                big_q  <= req_prot && rd_desc.big;
            end
        end
    end

    always_comb begin
        lin_valid    = 1'b0;
        lin_fault    = 1'b0;
        lin_addr     = '0;
        lin_opsize32 = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_REAL_DONE: begin
                lin_valid = 1'b1;
                lin_addr  = addr_q;
            end
            ST_PROT_DONE: begin
                lin_valid    = 1'b1;
                lin_addr     = addr_q;
                lin_opsize32 = big_q;
            end
            ST_LIMIT_FAULT: begin
                lin_fault = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/seg_xlat_unit_chk.sv
module seg_xlat_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_prot,
    input logic        lin_valid,
    input logic        lin_fault,
    input logic [31:0] lin_addr,
    input logic        lin_opsize32
);

    AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lin_valid && lin_fault)); // R9

    AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lin_fault |-> (lin_addr == 32'h0 && !lin_opsize32)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!lin_valid && !lin_fault)); // R2

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> (lin_valid || lin_fault)); // R2

    AST_REAL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_prot) |-> (lin_valid && !lin_fault && !lin_opsize32)); // R4

    AST_REAL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_prot) |-> (lin_addr[31:20] == 12'h0)); // R3

endmodule

bind seg_xlat_unit seg_xlat_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_prot     (req_prot),
    .lin_valid    (lin_valid),
    .lin_fault    (lin_fault),
    .lin_addr     (lin_addr),
    .lin_opsize32 (lin_opsize32)
);

// File: tb/seg_xlat_unit_test.sv
module seg_xlat_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cw_en = 1'b0, cw_local = 1'b0, cw_gran = 1'b0, cw_big = 1'b0;
    logic [1:0]  cw_idx = '0;
    logic [31:0] cw_base = '0;
    logic [19:0] cw_limit = '0;
    logic        req_valid = 1'b0, req_prot = 1'b0;
    logic [15:0] req_seg = '0;
    logic [31:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic        lin_valid, lin_fault, lin_opsize32;
    logic [31:0] lin_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_xlat_unit uut (
        .clk(clk), .rst_n(rst_n),
        .cw_en(cw_en), .cw_local(cw_local), .cw_idx(cw_idx), .cw_base(cw_base),
        .cw_limit(cw_limit), .cw_gran(cw_gran), .cw_big(cw_big),
        .req_valid(req_valid), .req_prot(req_prot), .req_seg(req_seg),
        .req_offset(req_offset), .req_size(req_size),
        .lin_valid(lin_valid), .lin_fault(lin_fault), .lin_addr(lin_addr),
        .lin_opsize32(lin_opsize32)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic v, input logic f,
                              input logic [31:0] a, input logic op);
        check({tag, " valid"}, 32'(lin_valid), 32'(v));
        check({tag, " fault"}, 32'(lin_fault), 32'(f));
        check({tag, " addr"}, lin_addr, a);
        check({tag, " opsize"}, 32'(lin_opsize32), 32'(op));
    endtask

    task automatic load(input logic lcl, input logic [1:0] idx, input logic [31:0] b,
                        input logic [19:0] lim, input logic g, input logic big);
        @(negedge clk);
        cw_en = 1'b1; cw_local = lcl; cw_idx = idx; cw_base = b;
        cw_limit = lim; cw_gran = g; cw_big = big;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    task automatic issue(input logic prot, input logic [15:0] seg,
                         input logic [31:0] off, input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1'b1; req_prot = prot; req_seg = seg;
        req_offset = off; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        expect_out("R1 reset", 1'b0, 1'b0, 32'h0, 1'b0);
        @(negedge clk);
        expect_out("R2 idle", 1'b0, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_real;
        issue(1'b0, 16'h1000, 32'h0000_0234, 2'd0);
        expect_out("R3 real basic", 1'b1, 1'b0, 32'h0001_0234, 1'b0);
        issue(1'b0, 16'hFFFF, 32'h0000_0010, 2'd2);
        expect_out("R3 real wrap", 1'b1, 1'b0, 32'h0000_0000, 1'b0);
        issue(1'b0, 16'h0001, 32'hABCD_0005, 2'd2);
        expect_out("R3 R4 real high offset", 1'b1, 1'b0, 32'h0000_0015, 1'b0);
    endtask

    task automatic t_cleared_cache;
        issue(1'b1, 16'h0000, 32'h0, 2'd0);
        expect_out("R12 cleared entry byte", 1'b1, 1'b0, 32'h0, 1'b0);
        issue(1'b1, 16'h0000, 32'h0, 2'd1);
        expect_out("R12 R6 cleared entry word", 1'b0, 1'b1, 32'h0, 1'b0);
    endtask

    task automatic t_byte_gran;
        load(1'b0, 2'd1, 32'h0040_0000, 20'h000FF, 1'b0, 1'b1);
        issue(1'b1, 16'h0008, 32'h0000_00FC, 2'd2);
        expect_out("R5 R6 R10 dword at limit", 1'b1, 1'b0, 32'h0040_00FC, 1'b1);
        issue(1'b1, 16'h0008, 32'h0000_00FD, 2'd2);
        expect_out("R6 R9 dword over limit", 1'b0, 1'b1, 32'h0, 1'b0);
        issue(1'b1, 16'h0008, 32'h0000_00FF, 2'd0);
        expect_out("R8 byte at limit", 1'b1, 1'b0, 32'h0040_00FF, 1'b1);
        issue(1'b1, 16'h0008, 32'h0000_00FD, 2'd3);
        expect_out("R8 code3 is dword", 1'b0, 1'b1, 32'h0, 1'b0);
        issue(1'b1, 16'h0008, 32'h0000_00FE, 2'd1);
        expect_out("R8 word at limit", 1'b1, 1'b0, 32'h0040_00FE, 1'b1);
    endtask

    task automatic t_page_gran;
        load(1'b1, 2'd2, 32'hF000_0000, 20'h00002, 1'b1, 1'b0);
        issue(1'b1, 16'h0014, 32'h0000_2FFE, 2'd1);
        expect_out("R7 word at scaled limit", 1'b1, 1'b0, 32'hF000_2FFE, 1'b0);
        issue(1'b1, 16'h0014, 32'h0000_2FFF, 2'd1);
        expect_out("R7 word past scaled limit", 1'b0, 1'b1, 32'h0, 1'b0);
        load(1'b0, 2'd3, 32'h8000_0000, 20'hFFFFF, 1'b1, 1'b1);
        issue(1'b1, 16'h0018, 32'h9000_0000, 2'd0);
        expect_out("R5 base wrap", 1'b1, 1'b0, 32'h1000_0000, 1'b1);
        issue(1'b1, 16'h0018, 32'hFFFF_FFFC, 2'd2);
        expect_out("R13 last dword", 1'b1, 1'b0, 32'h7FFF_FFFC, 1'b1);
        issue(1'b1, 16'h0018, 32'hFFFF_FFFE, 2'd2);
        expect_out("R13 end past top", 1'b0, 1'b1, 32'h0, 1'b0);
    endtask

    task automatic t_select;
        load(1'b1, 2'd1, 32'h0123_4000, 20'hFFFFF, 1'b0, 1'b0);
        issue(1'b1, 16'h000C, 32'h10, 2'd0);
        expect_out("R11 local bank", 1'b1, 1'b0, 32'h0123_4010, 1'b0);
        issue(1'b1, 16'hFFE8, 32'h10, 2'd0);
        expect_out("R11 high bits ignored", 1'b1, 1'b0, 32'h0040_0010, 1'b1);
        issue(1'b1, 16'h000B, 32'h10, 2'd0);
        expect_out("R11 low bits ignored", 1'b1, 1'b0, 32'h0040_0010, 1'b1);
    endtask

    task automatic t_write_collision;
        @(negedge clk);
        cw_en = 1'b1; cw_local = 1'b0; cw_idx = 2'd0; cw_base = 32'h0000_5000;
        cw_limit = 20'hFFFFF; cw_gran = 1'b0; cw_big = 1'b0;
        req_valid = 1'b1; req_prot = 1'b1; req_seg = 16'h0000;
        req_offset = 32'h0; req_size = 2'd0;
        @(negedge clk);
        cw_en = 1'b0; req_valid = 1'b0;
        expect_out("R12 same cycle old entry", 1'b1, 1'b0, 32'h0, 1'b0);
        issue(1'b1, 16'h0000, 32'h0, 2'd0);
        expect_out("R12 new entry visible", 1'b1, 1'b0, 32'h0000_5000, 1'b0);
    endtask

    task automatic t_pipeline;
        @(negedge clk);
        req_valid = 1'b1; req_prot = 1'b0; req_seg = 16'h0200; req_offset = 32'h3; req_size = 2'd0;
        @(negedge clk);
        expect_out("R2 first of pair", 1'b1, 1'b0, 32'h0000_2003, 1'b0);
        req_prot = 1'b1; req_seg = 16'h0008; req_offset = 32'h0000_0100; req_size = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        expect_out("R2 second of pair", 1'b0, 1'b1, 32'h0, 1'b0);
        @(negedge clk);
        expect_out("R2 idle after pair", 1'b0, 1'b0, 32'h0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_real();
        t_cleared_cache();
        t_byte_gran();
        t_page_gran();
        t_select();
        t_write_collision();
        t_pipeline();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule